// File: doc/BRIEF.md
# Small-Page NAND Command Front End

This block is the device side of a small-page NAND flash model with an 8-bit I/O bus. A host drives command bytes (with `cle`), address bytes (with `ale`) and data bytes (with both low), each qualified by a one-cycle `we` pulse while `ce_n` is low. The block decodes the commands and assembles the address. It captures program data into an internal page buffer. It hands program, erase and page-load requests to a separate storage engine.

Reads use a one-cycle `re` pulse. The byte appears on `dout` after the next clock edge. Array bytes come from the storage engine through a combinational byte port (`arr_page`, `arr_col` to `arr_rdata`). ID bytes and status bytes come from the block itself. The ready output always reports ready.

The address is three bytes. Byte 0 is the column and lands in bits 7:0. Byte 1 is the page low byte (bits 15:8) and byte 2 is the page high byte (bits 23:16). One page holds `PAGE_BYTES` data bytes plus `PAGE_BYTES/32` spare bytes, which is 528 bytes by default.

Top module: `nand_cmd_front`

## Requirements
- R1: A command byte is taken only on a `we` pulse with `ce_n` low and `cle` high. Address and data bytes also need `ce_n` low. Bytes written while `ce_n` is high change nothing.
- R2: Opcode 0x90 followed by one address byte makes the next four reads return the manufacturer code (0xEC), the device code (0x73), a filler byte (0xA5) and 0xC0. Any further read returns 0x00.
- R3: Opcode 0x70 makes the next read return the status byte, and a second read returns 0x00. In the status byte, bit 7 is 1 when `wp_n` is high, bit 6 (busy) is 0 and bit 0 (error) is 0.
- R4: After opcode 0x00 and three address bytes, the first read pulses `load_req` and presents the addressed page on `arr_page` and the column on `arr_col`. Later reads stream the following columns without any new load.
- R5: Opcode 0x01 adds 0x100 to the start column, and opcode 0x50 adds `PAGE_BYTES`. Either offset is cleared by the next page load or by an accepted program confirm.
- R6: A load makes (page + spare − start column) bytes available. Each byte read increments the address. Once no bytes remain, the next read loads again from the incremented address with the offset cleared.
- R7: After opcode 0x80 and three address bytes, data bytes fill the page buffer from index 0. They are readable on `buf_raddr`/`buf_rdata`. Bytes beyond page + spare are dropped.
- R8: Opcode 0x10 with `wp_n` high gives a one-cycle `prog_req`. At the same time `req_page` carries the page, `prog_col` carries the column plus offset, and `prog_len` carries the number of captured bytes.
- R9: Opcode 0x60, then two address bytes (page low, page high), then 0xD0 with `wp_n` high gives a one-cycle `erase_req`. `req_page` then holds the page with its low `ERASE_SHIFT` bits cleared.
- R10: While `wp_n` is low, opcodes 0x10 and 0xD0 raise no request.
- R11: Opcode 0xFF returns the block to read mode at address 0 with the offset cleared. It leaves only bit 7 set in the status byte.
- R12: A read with `ce_n` high returns 0x00, raises no load, and leaves the read position unchanged.
- R13: An unknown opcode starts no action and does not disturb a stream in progress. `ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| wp_n | input | 1 | Write protect, active low |
| we | input | 1 | One-cycle write strobe for `din` |
| re | input | 1 | One-cycle read strobe |
| din | input | 8 | Byte from the host |
| dout | output | 8 | Byte returned by the last read strobe |
| ready | output | 1 | Ready/busy, always ready |
| prog_req | output | 1 | Program request pulse |
| erase_req | output | 1 | Erase request pulse |
| req_page | output | 16 | Page for program or erase |
| prog_col | output | 10 | Start column for program |
| prog_len | output | 10 | Number of bytes to program |
| buf_raddr | input | 10 | Page-buffer read index from the engine |
| buf_rdata | output | 8 | Page-buffer byte at `buf_raddr` |
| load_req | output | 1 | Page-load request, coincident with a read strobe |
| arr_page | output | 16 | Page addressed for array reads |
| arr_col | output | 10 | Column addressed for array reads |
| arr_rdata | input | 8 | Array byte from the engine for `arr_page`/`arr_col` |

## Verification
Page reads are tried with three start columns: the plain read, the second-half read and the spare-area read. This separates the three offsets, and each byte is a function of both page and column, so a wrong page or a wrong column shows up as a different byte. A spare-area read that starts at the last byte tells apart the available-length arithmetic from the wrap to a fresh load at the incremented address. Program runs with a short burst, a spare-area start and an overlong burst separate column, offset and capping. Erase runs with a misaligned page, and program and erase runs with `wp_n` low, show that alignment and protection are applied. Reads and writes with `ce_n` high, an unknown opcode and the reset opcode are placed in the middle of a stream, so any lost or disturbed state appears in the next byte.

// File: rtl/nand_fe_pkg.sv
// Shared opcodes and read-source encoding for the NAND command front end.
package nand_fe_pkg;
    localparam logic [7:0] OP_READ_A     = 8'h00;
    localparam logic [7:0] OP_READ_B     = 8'h01;
    localparam logic [7:0] OP_READ_SPARE = 8'h50;
    localparam logic [7:0] OP_READ_ID    = 8'h90;
    localparam logic [7:0] OP_RESET      = 8'hFF;
    localparam logic [7:0] OP_PROG_SETUP = 8'h80;
    localparam logic [7:0] OP_PROG_GO    = 8'h10;
    localparam logic [7:0] OP_ERASE_SET  = 8'h60;
    localparam logic [7:0] OP_ERASE_GO   = 8'hD0;
    localparam logic [7:0] OP_STATUS     = 8'h70;
    localparam logic [7:0] ID_TAIL_BYTE  = 8'hC0;

    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_ID    = 2'd1,
        SRC_STAT  = 2'd2
    } rd_src_t;
endpackage

// File: rtl/nand_page_buf.sv
// Program capture buffer.
// Stores incoming data bytes in order from index 0 until TOTAL bytes are held.
// Extra bytes are dropped. The storage engine reads the buffer through a
// combinational port. Assumes clr and wr_en never arrive in the same cycle.
module nand_page_buf #(
    parameter int TOTAL = 528,
    parameter int AW    = 10,
    parameter int LW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    output logic [LW-1:0] fill
);
    logic [7:0] mem [TOTAL];
    logic       room;

    assign room = fill < LW'(TOTAL);

    // Fill counter: restarts on clr, advances on each stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill <= '0;
        else if (clr)
            fill <= '0;
        else if (wr_en && room)
            fill <= fill + LW'(1);
    end

    // Byte storage, written at the current fill index.
    always_ff @(posedge clk) begin
        if (wr_en && room)
            mem[fill[AW-1:0]] <= wr_data;
    end

    // Engine read port; out-of-range index returns erased value.
    always_comb begin
        if (raddr < AW'(TOTAL))
            rdata = mem[raddr];
        else
            rdata = 8'hFF;
    end

    assert_fill_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= LW'(TOTAL));

    assert_fill_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> ((fill == $past(fill) + LW'(1)) ||
                             ($past(fill) == LW'(TOTAL))));
endmodule

// File: rtl/nand_read_port.sv
// Read data path.
// Serves array bytes from the storage engine, ID bytes and the status snapshot.
// The first read of a pending page read raises a page load and returns the
// first byte in the same strobe. Assumes read strobes and command writes do
// not share a cycle.
module nand_read_port
    import nand_fe_pkg::*;
#(
    parameter int         TOTAL  = 528,
    parameter int         COL_W  = 10,
    parameter int         LEN_W  = 10,
    parameter int         ADDR_W = 24,
    parameter int         PAGE_W = 16,
    parameter logic [7:0] MANUF  = 8'hEC,
    parameter logic [7:0] DEVICE = 8'h73,
    parameter logic [7:0] FILLER = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic              ce_n,
    input  logic              cmd_is_read,
    input  logic              clear,
    input  logic              start_id,
    input  logic              start_stat,
    input  logic [7:0]        stat_val,
    input  logic [ADDR_W-1:0] addr,
    input  logic [COL_W-1:0]  offset,
    input  logic [7:0]        arr_rdata,
    output logic              consume,
    output logic              load_req,
    output logic [PAGE_W-1:0] arr_page,
    output logic [COL_W-1:0]  arr_col,
    output logic [7:0]        dout
);
    logic [LEN_W-1:0]  remain_q;
    logic [COL_W-1:0]  ptr_q;
    logic [PAGE_W-1:0] page_q;
    logic [7:0]        stat_q;
    rd_src_t           src_q;

    logic              strobe;
    logic              pending;
    logic [COL_W-1:0]  start_col;
    logic              col_ok;
    logic [7:0]        byte_val;
    logic              has_byte;
    logic [7:0]        id_byte;

    assign strobe    = re && !ce_n;
    assign pending   = cmd_is_read && (remain_q == '0);
    assign start_col = COL_W'(addr[7:0]) + offset;
    assign col_ok    = start_col < COL_W'(TOTAL);
    assign arr_col   = pending ? start_col : ptr_q;
    assign arr_page  = pending ? addr[ADDR_W-1:8] : page_q;
    assign load_req  = strobe && pending;
    assign consume   = strobe && has_byte;

    // ID byte picked by position.
    always_comb begin
        case (ptr_q[1:0])
            2'd0:    id_byte = MANUF;
            2'd1:    id_byte = DEVICE;
            2'd2:    id_byte = FILLER;
            default: id_byte = ID_TAIL_BYTE;
        endcase
    end

    // Select the byte served by a read and whether one is available.
    always_comb begin
        byte_val = 8'h00;
        has_byte = 1'b0;
        if (pending) begin
            has_byte = col_ok;
            byte_val = col_ok ? arr_rdata : 8'h00;
        end else if (remain_q != '0) begin
            has_byte = 1'b1;
            case (src_q)
                SRC_ID:   byte_val = id_byte;
                SRC_STAT: byte_val = stat_q;
                default:  byte_val = arr_rdata;
            endcase
        end
    end

    // Stream state: remaining count, pointer, loaded page and source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            ptr_q    <= '0;
            page_q   <= '0;
            stat_q   <= '0;
            src_q    <= SRC_ARRAY;
        end else if (clear) begin
            remain_q <= '0;
            src_q    <= SRC_ARRAY;
        end else if (start_id) begin
            remain_q <= LEN_W'(4);
            ptr_q    <= '0;
            src_q    <= SRC_ID;
        end else if (start_stat) begin
            remain_q <= LEN_W'(1);
            ptr_q    <= '0;
            stat_q   <= stat_val;
            src_q    <= SRC_STAT;
        end else if (load_req) begin
            page_q   <= addr[ADDR_W-1:8];
            ptr_q    <= start_col + COL_W'(1);
            src_q    <= SRC_ARRAY;
            remain_q <= col_ok ? (LEN_W'(TOTAL) - LEN_W'(start_col) - LEN_W'(1))
                               : '0;
        end else if (strobe && remain_q != '0) begin
            remain_q <= remain_q - LEN_W'(1);
            ptr_q    <= ptr_q + COL_W'(1);
        end
    end

    // Output byte register, updated on every read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= 8'h00;
        else if (re)
            dout <= (strobe && has_byte) ? byte_val : 8'h00;
    end

    assert_ce_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (re && ce_n) |=> (dout == 8'h00 && $stable(remain_q) && $stable(ptr_q)));

    assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !pending && remain_q != '0 && !clear && !start_id && !start_stat)
            |=> (remain_q == $past(remain_q) - LEN_W'(1)));
endmodule

// File: rtl/nand_cmd_front.sv
// NAND command front end (small-page, 8-bit bus).
// Decodes command bytes, assembles the three-byte address, tracks the read
// offset and status, and issues program and erase requests. Page loads and
// byte service go through nand_read_port; program data goes into
// nand_page_buf. Assumes at most one of we/re per cycle.
module nand_cmd_front
    import nand_fe_pkg::*;
#(
    parameter int         PAGE_BYTES  = 512,
    parameter int         ADDR_BYTES  = 3,
    parameter int         ERASE_SHIFT = 5,
    parameter logic [7:0] MANUF_CODE  = 8'hEC,
    parameter logic [7:0] DEVICE_CODE = 8'h73,
    parameter logic [7:0] FILL_CODE   = 8'hA5,
    localparam int SPARE_BYTES = PAGE_BYTES / 32,
    localparam int TOTAL       = PAGE_BYTES + SPARE_BYTES,
    localparam int ADDR_W      = 8 * ADDR_BYTES,
    localparam int PAGE_W      = ADDR_W - 8,
    localparam int COL_W       = $clog2(PAGE_BYTES + 256),
    localparam int LEN_W       = $clog2(TOTAL + 1),
    localparam int BUF_AW      = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              cle,
    input  logic              ale,
    input  logic              wp_n,
    input  logic              we,
    input  logic              re,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              ready,
    output logic              prog_req,
    output logic              erase_req,
    output logic [PAGE_W-1:0] req_page,
    output logic [COL_W-1:0]  prog_col,
    output logic [LEN_W-1:0]  prog_len,
    input  logic [BUF_AW-1:0] buf_raddr,
    output logic [7:0]        buf_rdata,
    output logic              load_req,
    output logic [PAGE_W-1:0] arr_page,
    output logic [COL_W-1:0]  arr_col,
    input  logic [7:0]        arr_rdata
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [PAGE_W-1:0] BLK_MASK = ~((PAGE_W'(1) << ERASE_SHIFT) - PAGE_W'(1));
    localparam logic [COL_W-1:0] HALF_OFF  = COL_W'(256);
    localparam logic [COL_W-1:0] SPARE_OFF = COL_W'(PAGE_BYTES);

    logic [7:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  acnt_q;
    logic [COL_W-1:0]  offset_q;
    logic [6:0]        stat_low_q;
    logic              wp_q;

    logic              cmd_wr, adr_wr, dat_wr;
    logic              addr_done, id_go, stat_go, rd_clear, buf_clr;
    logic [7:0]        cmd_next;
    logic              consume;
    logic [LEN_W-1:0]  fill;

    assign ready    = 1'b1;
    assign cmd_wr   = we && !ce_n && cle;
    assign adr_wr   = we && !ce_n && ale && !cle;
    assign dat_wr   = we && !ce_n && !cle && !ale && (cmd_q == OP_PROG_SETUP);
    assign cmd_next = (din == OP_READ_B || din == OP_READ_SPARE) ? OP_READ_A : din;

    assign addr_done = adr_wr && (acnt_q == CNT_W'(ADDR_BYTES - 1));
    assign id_go     = adr_wr && (acnt_q == '0) && (cmd_q == OP_READ_ID);
    assign stat_go   = cmd_wr && (din == OP_STATUS);
    assign rd_clear  = (addr_done && cmd_q == OP_READ_A) || (cmd_wr && din == OP_RESET);
    assign buf_clr   = addr_done && (cmd_q == OP_PROG_SETUP);

    // Command, address, offset, status and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= OP_READ_A;
            addr_q     <= '0;
            acnt_q     <= '0;
            offset_q   <= '0;
            stat_low_q <= '0;
            wp_q       <= 1'b0;
            prog_req   <= 1'b0;
            erase_req  <= 1'b0;
            req_page   <= '0;
            prog_col   <= '0;
            prog_len   <= '0;
        end else begin
            wp_q      <= wp_n;
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            if (cmd_wr) begin
                acnt_q <= '0;
                cmd_q  <= cmd_next;
                case (din)
                    OP_READ_A:     offset_q <= '0;
                    OP_READ_B:     offset_q <= HALF_OFF;
                    OP_READ_SPARE: offset_q <= SPARE_OFF;
                    OP_PROG_GO: begin
                        if (wp_n) begin
                            prog_req <= 1'b1;
                            req_page <= addr_q[ADDR_W-1:8];
                            prog_col <= COL_W'(addr_q[7:0]) + offset_q;
                            prog_len <= fill;
                            offset_q <= '0;
                        end
                    end
                    OP_ERASE_GO: begin
                        addr_q <= {addr_q[ADDR_W-9:0], 8'h00};
                        if (wp_n) begin
                            erase_req <= 1'b1;
                            req_page  <= addr_q[PAGE_W-1:0] & BLK_MASK;
                        end
                    end
                    OP_RESET: begin
                        cmd_q      <= OP_READ_A;
                        addr_q     <= '0;
                        offset_q   <= '0;
                        stat_low_q <= '0;
                    end
                    default: ;
                endcase
            end else if (adr_wr) begin
                for (int i = 0; i < ADDR_BYTES; i++) begin
                    if (acnt_q == CNT_W'(i))
                        addr_q[8*i +: 8] <= din;
                end
                if (acnt_q != CNT_MAX)
                    acnt_q <= acnt_q + CNT_W'(1);
            end else begin
                if (load_req)
                    offset_q <= '0;
                if (consume)
                    addr_q <= addr_q + ADDR_W'(1);
            end
        end
    end

    nand_page_buf #(
        .TOTAL (TOTAL),
        .AW    (BUF_AW),
        .LW    (LEN_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (dat_wr),
        .wr_data (din),
        .raddr   (buf_raddr),
        .rdata   (buf_rdata),
        .fill    (fill)
    );

    nand_read_port #(
        .TOTAL  (TOTAL),
        .COL_W  (COL_W),
        .LEN_W  (LEN_W),
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .MANUF  (MANUF_CODE),
        .DEVICE (DEVICE_CODE),
        .FILLER (FILL_CODE)
    ) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .re          (re),
        .ce_n        (ce_n),
        .cmd_is_read (cmd_q == OP_READ_A),
        .clear       (rd_clear),
        .start_id    (id_go),
        .start_stat  (stat_go),
        .stat_val    ({wp_q, stat_low_q}),
        .addr        (addr_q),
        .offset      (offset_q),
        .arr_rdata   (arr_rdata),
        .consume     (consume),
        .load_req    (load_req),
        .arr_page    (arr_page),
        .arr_col     (arr_col),
        .dout        (dout)
    );

    assert_cmd_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ce_n) |=> ($stable(cmd_q) && $stable(addr_q) && $stable(acnt_q)));

    assert_prog_wp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> $past(wp_n));

    assert_erase_wp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(wp_n));

    assert_req_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, erase_req}));
endmodule

// File: tb/nand_cmd_front_bench.sv
module nand_cmd_front_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, cle = 1'b0, ale = 1'b0, wp_n = 1'b1;
    logic        we = 1'b0, re = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [9:0]  buf_raddr = '0;
    logic [7:0]  dout, buf_rdata, arr_rdata;
    logic        ready, prog_req, erase_req, load_req;
    logic [15:0] req_page, arr_page;
    logic [9:0]  prog_col, prog_len, arr_col;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    // Storage engine model: byte depends on page and column.
    function automatic logic [7:0] pat(input logic [15:0] pg, input logic [9:0] cl);
        return pg[7:0] ^ (pg[15:8] << 1) ^ cl[7:0] ^ {4'h0, cl[9:8], 2'b00} ^ 8'h3C;
    endfunction
    assign arr_rdata = pat(arr_page, arr_col);

    nand_cmd_front u_nand_cmd_front (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
        .we(we), .re(re), .din(din), .dout(dout), .ready(ready),
        .prog_req(prog_req), .erase_req(erase_req), .req_page(req_page),
        .prog_col(prog_col), .prog_len(prog_len), .buf_raddr(buf_raddr),
        .buf_rdata(buf_rdata), .load_req(load_req), .arr_page(arr_page),
        .arr_col(arr_col), .arr_rdata(arr_rdata)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic wr_byte(input logic c, input logic a, input logic [7:0] v);
        cle = c; ale = a; din = v; we = 1'b1;
        @(negedge clk);
        we = 1'b0; cle = 1'b0; ale = 1'b0;
    endtask
    task automatic wr_cmd(input logic [7:0] v);  wr_byte(1'b1, 1'b0, v); endtask
    task automatic wr_addr(input logic [7:0] v); wr_byte(1'b0, 1'b1, v); endtask
    task automatic wr_data(input logic [7:0] v); wr_byte(1'b0, 1'b0, v); endtask

    task automatic rd(output logic [7:0] val, output logic ld,
                      output logic [15:0] pg, output logic [9:0] cl);
        re = 1'b1;
        #1;
        ld = load_req; pg = arr_page; cl = arr_col;
        @(negedge clk);
        re = 1'b0;
        val = dout;
    endtask

    task automatic t_reset_state;
        check("R13 ready after reset", ready, 1);
        check("R4 dout after reset", dout, 0);
        check("R8 prog_req idle", prog_req, 0);
        check("R9 erase_req idle", erase_req, 0);
    endtask

    task automatic t_read_id;
        logic [7:0] v; logic ld; logic [15:0] pg; logic [9:0] cl;
        wr_cmd(8'h90); wr_addr(8'h00);
        rd(v, ld, pg, cl); check("R2 id byte0", v, 8'hEC); check("R2 no load", ld, 0);
        rd(v, ld, pg, cl); check("R2 id byte1", v, 8'h73);
        rd(v, ld, pg, cl); check("R2 id byte2", v, 8'hA5);
        rd(v, ld, pg, cl); check("R2 id byte3", v, 8'hC0);
        rd(v, ld, pg, cl); check("R2 id exhausted", v, 8'h00);
    endtask

    task automatic t_status;
        logic [7:0] v; logic ld; logic [15:0] pg; logic [9:0] cl;
        wr_cmd(8'h70);
        rd(v, ld, pg, cl); check("R3 status unprotected", v, 8'h80);
        rd(v, ld, pg, cl); check("R3 status second read", v, 8'h00);
        wp_n = 1'b0; @(negedge clk);
        wr_cmd(8'h70);
        rd(v, ld, pg, cl); check("R3 status protected", v, 8'h00);
        wp_n = 1'b1; @(negedge clk);
    endtask

    task automatic t_read_main;
        logic [7:0] v; logic ld; logic [15:0] pg; logic [9:0] cl;
        wr_cmd(8'h00); wr_addr(8'h05); wr_addr(8'h12); wr_addr(8'h00);
        rd(v, ld, pg, cl);
        check("R4 first read loads", ld, 1);
        check("R4 load page", pg, 16'h0012);
        check("R4 load column", cl, 5);
        check("R4 first byte", v, pat(16'h0012, 10'd5));
        for (int k = 1; k < 4; k++) begin
            rd(v, ld, pg, cl);
            check("R4 stream no reload", ld, 0);
            check("R4 stream byte", v, pat(16'h0012, 10'(5 + k)));
        end
    endtask

    task automatic t_read_offsets;
        logic [7:0] v; logic ld; logic [15:0] pg; logic [9:0] cl;
        wr_cmd(8'h01); wr_addr(8'h02); wr_addr(8'h34); wr_addr(8'h00);
        rd(v, ld, pg, cl);
        check("R5 half-page column", cl, 10'h102);
        check("R5 half-page byte", v, pat(16'h0034, 10'h102));
        wr_cmd(8'h50); wr_addr(8'h03); wr_addr(8'h35); wr_addr(8'h00);
        rd(v, ld, pg, cl);
        check("R5 spare column", cl, 10'h203);
        check("R5 spare byte", v, pat(16'h0035, 10'h203));
    endtask

    task automatic t_read_tail;
        logic [7:0] v; logic ld; logic [15:0] pg; logic [9:0] cl;
        wr_cmd(8'h50); wr_addr(8'h0F); wr_addr(8'h40); wr_addr(8'h00);
        rd(v, ld, pg, cl);
        check("R6 last spare column", cl, 527);
        check("R6 last spare byte", v, pat(16'h0040, 10'd527));
        rd(v, ld, pg, cl);
        check("R6 reload after exhaustion", ld, 1);
        check("R6 reload page", pg, 16'h0040);
        check("R6 reload column offset cleared", cl, 10'h010);
        check("R6 reload byte", v, pat(16'h0040, 10'h010));
    endtask

    task automatic t_program;
        wr_cmd(8'h80); wr_addr(8'h04); wr_addr(8'h21); wr_addr(8'h00);
        for (int k = 0; k < 5; k++) wr_data(8'hA0 + 8'(k));
        wr_cmd(8'h10);
        check("R8 prog_req pulse", prog_req, 1);
        check("R8 prog page", req_page, 16'h0021);
        check("R8 prog column", prog_col, 4);
        check("R8 prog length", prog_len, 5);
        @(negedge clk);
        check("R8 prog_req one cycle", prog_req, 0);
        for (int k = 0; k < 5; k++) begin
            buf_raddr = 10'(k); #1;
            check("R7 buffer byte", buf_rdata, 8'hA0 + k);
        end
        wr_cmd(8'h50); wr_cmd(8'h80); wr_addr(8'h01); wr_addr(8'h22); wr_addr(8'h00);
        wr_data(8'h11); wr_data(8'h22);
        wr_cmd(8'h10);
        check("R5 spare program column", prog_col, 10'h201);
        check("R8 spare program length", prog_len, 2);
        wr_cmd(8'h80); wr_addr(8'h00); wr_addr(8'h23); wr_addr(8'h00);
        for (int k = 0; k < 530; k++) wr_data(8'(k));
        wr_cmd(8'h10);
        check("R7 capped length", prog_len, 528);
        buf_raddr = 10'd527; #1;
        check("R7 last stored byte", buf_rdata, 8'h0F);
        buf_raddr = 10'd0; #1;
        check("R7 overflow not wrapped", buf_rdata, 8'h00);
    endtask

    task automatic t_erase;
        wr_cmd(8'h60); wr_addr(8'h47); wr_addr(8'h01);
        wr_cmd(8'hD0);
        check("R9 erase_req pulse", erase_req, 1);
        check("R9 erase block page", req_page, 16'h0140);
        check("R9 no program on erase", prog_req, 0);
    endtask

    task automatic t_protect;
        wp_n = 1'b0;
        wr_cmd(8'h80); wr_addr(8'h00); wr_addr(8'h30); wr_addr(8'h00);
        wr_data(8'h55);
        wr_cmd(8'h10);
        check("R10 program blocked", prog_req, 0);
        wr_cmd(8'h60); wr_addr(8'h20); wr_addr(8'h00);
        wr_cmd(8'hD0);
        check("R10 erase blocked", erase_req, 0);
        @(negedge clk);
        check("R10 still no request", prog_req | erase_req, 0);
        wp_n = 1'b1; @(negedge clk);
    endtask

    task automatic t_reset_cmd;
        logic [7:0] v; logic ld; logic [15:0] pg; logic [9:0] cl;
        wr_cmd(8'h01); wr_addr(8'h09); wr_addr(8'h09); wr_addr(8'h00);
        wr_cmd(8'hFF);
        rd(v, ld, pg, cl);
        check("R11 load after reset", ld, 1);
        check("R11 page zero", pg, 0);
        check("R11 column zero", cl, 0);
        wr_cmd(8'h70);
        rd(v, ld, pg, cl);
        check("R11 status after reset", v, 8'h80);
    endtask

    task automatic t_ce_high;
        logic [7:0] v; logic ld; logic [15:0] pg; logic [9:0] cl;
        wr_cmd(8'h00); wr_addr(8'h10); wr_addr(8'h50); wr_addr(8'h00);
        rd(v, ld, pg, cl);
        check("R4 column 0x10", cl, 10'h010);
        ce_n = 1'b1;
        rd(v, ld, pg, cl);
        check("R12 disabled read byte", v, 8'h00);
        check("R12 disabled read no load", ld, 0);
        wr_cmd(8'h70);
        ce_n = 1'b0;
        rd(v, ld, pg, cl);
        check("R12 stream position kept", cl, 10'h011);
        check("R1 disabled command ignored", v, pat(16'h0050, 10'h011));
        wr_cmd(8'h85);
        check("R13 unknown no prog", prog_req, 0);
        check("R13 unknown no erase", erase_req, 0);
        rd(v, ld, pg, cl);
        check("R13 unknown no load", ld, 0);
        check("R13 stream continues", v, pat(16'h0050, 10'h012));
        check("R13 ready stays high", ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ce_n  = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_read_id();
        t_status();
        t_read_main();
        t_read_offsets();
        t_read_tail();
        t_program();
        t_erase();
        t_protect();
        t_reset_cmd();
        t_ce_high();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule